// File: doc/BRIEF.md
# Buffered-Compare 8-bit PWM Timer

This block is an 8-bit up-counting timer that drives one pulse-width-modulated output. Two compare values control it: a period compare (N) and a width compare (M). The counter runs from 00H up to N, then returns to 00H. That wrap raises a one-clock match interrupt. The output is high while the count is below the working width value and low for the rest of the period.

The count clock does not arrive as a clock. It is one of several one-cycle tick sources, and a 3-bit select field chooses which source the counter follows. Software writes both compares through a single write port. The period compare takes effect at once. A width write lands in a buffer and reaches the working compare only on the third tick after the write, so the width can be changed while the timer runs without a glitch in the current count.

Stopping the timer invalidates the working width. After a restart, the output stays low until the width is written again and has transferred, even when the value is the same as before. The write port keeps the rule width < period by refusing any write that would break it.

Top module: `bcmp_pwm_timer`

## Requirements
- R1: After reset, `pwm_out`, `match_irq` and `width_ready` are all 0. The period compare resets to FFH and the buffered width resets to 00H.
- R2: The counter advances only on cycles where `tick_src[clk_sel]` is 1. Pulses on any other `tick_src` bit have no effect.
- R3: While `run` is 1, `match_irq` pulses high for exactly one clock each time the count reaches the period compare N on a tick. Successive pulses are N+1 ticks apart. The count then restarts at 00H.
- R4: Within each period, `pwm_out` is 1 for exactly M ticks, at counts 00H to M-1. It is 0 for the remaining N-M+1 ticks. M=0 gives an output that never goes high.
- R5: An accepted width write (`wr_sel`=1) loads the buffer and takes effect at the third tick after the write cycle. `width_ready` is 0 from the write until that tick and 1 afterwards. A second accepted width write before the transfer completes restarts the three-tick count.
- R6: When `run` falls, the working width becomes invalid and any pending transfer is dropped. After a restart, `pwm_out` stays 0 and `width_ready` stays 0 until a new width write has transferred, even if the written value is unchanged. The period counting and `match_irq` continue during this time.
- R7: A width write whose data is not below the current period compare is ignored. A period write (`wr_sel`=0) whose data is not above the buffered width is ignored.
- R8: While `run` is 0, the counter is held at 00H, `pwm_out` is 0 from the next clock on, and `match_irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Timer enable; 0 stops the timer and clears the count |
| clk_sel | input | 3 | Selects which `tick_src` bit is the count clock |
| tick_src | input | 8 | One-cycle count-tick pulses from 8 prescaler taps |
| wr_en | input | 1 | Compare write strobe |
| wr_sel | input | 1 | Write target: 0 = period compare, 1 = width compare |
| wr_data | input | 8 | Compare value to write |
| pwm_out | output | 1 | PWM output, active high |
| match_irq | output | 1 | One-clock pulse on a period match |
| width_ready | output | 1 | 1 when the working width is valid and no transfer is pending |

## Verification
The duty cycle and the interval between interrupts are measured for about twenty random (M, N) pairs. The corner pairs M=0/N=1 and M=254/N=255 are added to these. This separates a correct high-width count from off-by-one errors in the compare and in the wrap point. The transfer delay is tested with isolated single ticks, which shows whether the load happens on the second, third or fourth tick and whether a rewrite restarts the delay. A stop and restart with no rewrite, followed by a rewrite of the same value, separates a design that correctly invalidates the width from one that keeps the old value. Out-of-order compare writes and ticks on the wrong source bits must leave the interval and ready flag unchanged.

// File: rtl/bcmp_pwm_pkg.sv
package bcmp_pwm_pkg;

  typedef enum logic {
    TGT_PERIOD = 1'b0,
    TGT_WIDTH  = 1'b1
  } cmp_target_e;

  // Width must stay strictly below period: true when the pair is legal.
  function automatic logic pair_legal(input logic [15:0] width_v,
                                      input logic [15:0] period_v);
    return width_v < period_v;
  endfunction

endpackage

// File: rtl/bcmp_tick_sel.sv
module bcmp_tick_sel #(
  parameter int SRCS = 8,
  localparam int SEL_W = (SRCS > 1) ? $clog2(SRCS) : 1
) (
  input  logic [SRCS-1:0]  tick_src,
  input  logic [SEL_W-1:0] sel,
  output logic             count_en
);

  generate
    if (SRCS == 1) begin : g_single
      logic unused_sel;
      assign unused_sel = ^sel;
      assign count_en   = tick_src[0];
    end else if ((1 << SEL_W) == SRCS) begin : g_full
      assign count_en = tick_src[sel];
    end else begin : g_partial
      // Out-of-range selections give no ticks.
      assign count_en = (int'(sel) < SRCS) ? tick_src[sel] : 1'b0;
    end
  endgenerate

endmodule

// File: rtl/bcmp_cmp_regs.sv
module bcmp_cmp_regs
  import bcmp_pwm_pkg::*;
#(
  parameter int W          = 8,
  parameter int XFER_TICKS = 3,
  localparam int CW = (XFER_TICKS > 1) ? $clog2(XFER_TICKS) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  cmp_target_e  wr_tgt,
  input  logic [W-1:0] wr_data,
  input  logic         count_en,
  input  logic         stop_evt,
  output logic [W-1:0] period_val,
  output logic [W-1:0] width_buf,
  output logic [W-1:0] width_work,
  output logic         width_valid,
  output logic         xfer_pend,
  output logic         xfer_done,
  output logic         width_acc,
  output logic         period_acc
);

  logic [CW-1:0] xfer_cnt;
  logic          last_tick;

  // Acceptance checks keep width strictly below period at all times.
  assign width_acc  = wr_en && (wr_tgt == TGT_WIDTH) &&
                      pair_legal(16'(wr_data), 16'(period_val));
  assign period_acc = wr_en && (wr_tgt == TGT_PERIOD) &&
                      pair_legal(16'(width_buf), 16'(wr_data));

  assign last_tick = (xfer_cnt == CW'(XFER_TICKS - 1));
  assign xfer_done = xfer_pend && count_en && last_tick && !stop_evt && !width_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_val  <= '1;
      width_buf   <= '0;
      width_work  <= '0;
      width_valid <= 1'b0;
      xfer_pend   <= 1'b0;
      xfer_cnt    <= '0;
    end else begin
      if (period_acc) period_val <= wr_data;
      if (width_acc)  width_buf  <= wr_data;
      if (stop_evt) begin
        width_valid <= 1'b0;
        xfer_pend   <= 1'b0;
        xfer_cnt    <= '0;
      end else if (width_acc) begin
        xfer_pend <= 1'b1;
        xfer_cnt  <= '0;
      end else if (xfer_pend && count_en) begin
        if (last_tick) begin
          width_work  <= width_buf;
          width_valid <= 1'b1;
          xfer_pend   <= 1'b0;
          xfer_cnt    <= '0;
        end else begin
          xfer_cnt <= xfer_cnt + CW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/bcmp_count_core.sv
module bcmp_count_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         count_en,
  input  logic [W-1:0] period_val,
  input  logic [W-1:0] width_work,
  input  logic         width_valid,
  output logic         run_q,
  output logic         stop_evt,
  output logic         period_hit,
  output logic         irq_q,
  output logic         pwm
);

  logic [W-1:0] count_q;

  assign stop_evt   = run_q && !run;
  // A greater-or-equal match recovers if the period is lowered below the count.
  assign period_hit = run && count_en && (count_q >= period_val);
  assign pwm        = run_q && width_valid && (count_q < width_work);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      run_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      run_q <= run;
      irq_q <= period_hit;
      if (!run || period_hit) count_q <= '0;
      else if (count_en)      count_q <= count_q + W'(1);
    end
  end

endmodule

// File: rtl/bcmp_pwm_timer.sv
module bcmp_pwm_timer
  import bcmp_pwm_pkg::*;
#(
  parameter int W          = 8,
  parameter int SRCS       = 8,
  parameter int XFER_TICKS = 3,
  localparam int SEL_W = (SRCS > 1) ? $clog2(SRCS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic [SRCS-1:0]  tick_src,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [W-1:0]     wr_data,
  output logic             pwm_out,
  output logic             match_irq,
  output logic             width_ready
);

  logic         count_en;
  logic [W-1:0] period_val;
  logic [W-1:0] width_buf;
  logic [W-1:0] width_work;
  logic         width_valid;
  logic         xfer_pend;
  logic         xfer_done;
  logic         width_acc;
  logic         period_acc;
  logic         run_q;
  logic         stop_evt;
  logic         period_hit;
  cmp_target_e  wr_tgt;

  assign wr_tgt = cmp_target_e'(wr_sel);

  bcmp_tick_sel #(.SRCS(SRCS)) u_tick_sel (
    .tick_src (tick_src),
    .sel      (clk_sel),
    .count_en (count_en)
  );

  bcmp_cmp_regs #(.W(W), .XFER_TICKS(XFER_TICKS)) u_cmp_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_tgt      (wr_tgt),
    .wr_data     (wr_data),
    .count_en    (count_en),
    .stop_evt    (stop_evt),
    .period_val  (period_val),
    .width_buf   (width_buf),
    .width_work  (width_work),
    .width_valid (width_valid),
    .xfer_pend   (xfer_pend),
    .xfer_done   (xfer_done),
    .width_acc   (width_acc),
    .period_acc  (period_acc)
  );

  bcmp_count_core #(.W(W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .count_en    (count_en),
    .period_val  (period_val),
    .width_work  (width_work),
    .width_valid (width_valid),
    .run_q       (run_q),
    .stop_evt    (stop_evt),
    .period_hit  (period_hit),
    .irq_q       (match_irq),
    .pwm         (pwm_out)
  );

  assign width_ready = width_valid && !xfer_pend;

endmodule

// File: rtl/bcmp_pwm_timer_chk.sv
module bcmp_pwm_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         count_en,
  input logic         stop_evt,
  input logic         xfer_done,
  input logic [W-1:0] period_val,
  input logic [W-1:0] width_buf,
  input logic         pwm_out,
  input logic         match_irq,
  input logic         width_ready
);

  p_irq_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq |=> !match_irq);

  p_irq_from_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq |-> $past(count_en && run));

  p_ready_after_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(width_ready) |-> $past(count_en) && $past(xfer_done));

  p_stop_invalidates_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !width_ready && !pwm_out);

  p_width_below_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
    width_buf < period_val);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !pwm_out && !match_irq);

endmodule

bind bcmp_pwm_timer bcmp_pwm_timer_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run         (run),
  .count_en    (count_en),
  .stop_evt    (stop_evt),
  .xfer_done   (xfer_done),
  .period_val  (period_val),
  .width_buf   (width_buf),
  .pwm_out     (pwm_out),
  .match_irq   (match_irq),
  .width_ready (width_ready)
);

// File: tb/bcmp_pwm_timer_bench.sv
module bcmp_pwm_timer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [2:0] clk_sel = 3'd0;
  logic [7:0] tick_src = 8'h00;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       pwm_out;
  logic       match_irq;
  logic       width_ready;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bcmp_pwm_timer u_bcmp_pwm_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .clk_sel(clk_sel), .tick_src(tick_src),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pwm_out(pwm_out), .match_irq(match_irq), .width_ready(width_ready)
  );

  // Bench-side expectations, written from the requirements.
  function automatic int want_high(input int m, input int n);
    return (n > m) ? m : -1;
  endfunction
  function automatic int want_gap(input int n);
    return n + 1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic tgt, input int val);
    wr_en = 1'b1; wr_sel = tgt; wr_data = 8'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic one_tick();
    tick_src = 8'h01;
    @(negedge clk);
    tick_src = 8'h00;
    @(negedge clk);
  endtask

  // Waits for an interrupt, then counts high samples until the next one.
  task automatic measure(output int hi, output int gap);
    int k = 0;
    while (!match_irq && k < 700) begin @(negedge clk); k++; end
    hi = 0; gap = 0;
    do begin
      hi += int'(pwm_out);
      gap++;
      @(negedge clk);
    end while (!match_irq && gap < 700);
  endtask

  task automatic setup(input int m, input int n);
    run = 1'b0; clk_sel = 3'd0; tick_src = 8'hFF;
    @(negedge clk);
    put(1'b0, 255);
    put(1'b1, m);
    put(1'b0, n);
    cyc(4);
    run = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int hi, gap, m, n, irqs;
    void'($urandom(32'd2024));
    cyc(3);
    // R1 reset state
    check("R1 pwm", int'(pwm_out), 0);
    check("R1 irq", int'(match_irq), 0);
    check("R1 ready", int'(width_ready), 0);
    rst_n = 1'b1;
    cyc(2);

    // R4/R3 random pairs plus corners
    for (int i = 0; i < 22; i++) begin
      if (i == 0) begin m = 0; n = 1; end
      else if (i == 1) begin m = 254; n = 255; end
      else begin n = 1 + int'($urandom % 60); m = int'($urandom % n); end
      setup(m, n);
      check("R5 ready after setup", int'(width_ready), 1);
      measure(hi, gap);
      check("R4 high ticks", hi, want_high(m, n));
      check("R3 irq gap", gap, want_gap(n));
    end

    // R8 stopped: no output, no interrupt
    run = 1'b0;
    @(negedge clk);
    irqs = 0; hi = 0;
    for (int i = 0; i < 40; i++) begin
      irqs += int'(match_irq); hi += int'(pwm_out);
      @(negedge clk);
    end
    check("R8 irq while stopped", irqs, 0);
    check("R8 pwm while stopped", hi, 0);

    // R5 three-tick transfer latency and restart on rewrite
    setup(4, 20);
    tick_src = 8'h00;
    @(negedge clk);
    put(1'b1, 7);
    check("R5 ready after write", int'(width_ready), 0);
    one_tick(); check("R5 after tick1", int'(width_ready), 0);
    one_tick(); check("R5 after tick2", int'(width_ready), 0);
    one_tick(); check("R5 after tick3", int'(width_ready), 1);
    put(1'b1, 9);
    one_tick(); one_tick();
    put(1'b1, 9);
    one_tick(); one_tick();
    check("R5 rewrite restarts delay", int'(width_ready), 0);
    one_tick();
    check("R5 rewrite done", int'(width_ready), 1);
    tick_src = 8'hFF;
    measure(hi, gap);
    check("R5 new width in use", hi, 9);

    // R6 restart without rewrite
    setup(5, 12);
    run = 1'b0; cyc(2);
    run = 1'b1; cyc(6);
    check("R6 ready after restart", int'(width_ready), 0);
    measure(hi, gap);
    check("R6 pwm idle until rewrite", hi, 0);
    check("R6 irq keeps counting", gap, 13);
    put(1'b1, 5);
    cyc(4);
    check("R6 ready after same-value rewrite", int'(width_ready), 1);
    measure(hi, gap);
    check("R6 high after rewrite", hi, 5);

    // R7 illegal writes are ignored
    setup(3, 10);
    put(1'b1, 10);
    check("R7 width=period ignored", int'(width_ready), 1);
    put(1'b1, 200);
    check("R7 width>period ignored", int'(width_ready), 1);
    put(1'b0, 3);
    put(1'b0, 2);
    measure(hi, gap);
    check("R7 period<=width ignored", gap, 11);
    put(1'b0, 4);
    measure(hi, gap); measure(hi, gap);
    check("R7 legal period accepted", gap, 5);
    check("R7 width kept", hi, 3);

    // R2 only the selected source ticks
    setup(2, 3);
    clk_sel = 3'd5; tick_src = 8'hDF;
    cyc(2);
    irqs = 0;
    for (int i = 0; i < 30; i++) begin
      irqs += int'(match_irq);
      @(negedge clk);
    end
    check("R2 other sources ignored", irqs, 0);
    tick_src = 8'h20;
    measure(hi, gap);
    check("R2 selected source gap", gap, 4);
    check("R2 selected source high", hi, 2);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule